// File: doc/BRIEF.md
# Process Queue Link Manager

This block keeps the bookkeeping links for a fixed pool of process control blocks. Two singly linked lists share one link array, with one link word per process slot. The run queue holds processes that can use the CPU, in first-in first-out order. The spare pool holds slots that are not in use. A head register and a tail register describe each list. The stateword contents are not stored here. This block holds only the link words and the list descriptors.

Slot 0 is the idle process. It never leaves the run queue and always sits at its end. A link value of 0 marks the end of either list. The run queue is therefore described by its head and by the last non-idle entry. New work is spliced in just before the idle slot. The spare pool is an ordinary head/tail list that ends in 0.

A scheduler issues one command at a time on a command port: pop the next runnable process, requeue a process, create a process from the spare pool, or retire a process to the spare pool. The block walks a single-port link RAM in a fixed number of cycles and reports each command with a done pulse. The two list heads can be read at any time.

Top module: `pq_manager`

## Requirements
- R1: After reset, busy stays high for exactly NPROC = 2**PQ_PID_W cycles while the link array is preset. The block then shows ready_head = 0 (only idle runnable) and free_head = 1, and the spare pool holds 1, 2, ..., NPROC-1 in ascending order.
- R2: A command is taken in a cycle where busy is low and cmd_valid is high. busy is then high for exactly four cycles, and done is high in the fourth of them only. rsp_pid and rsp_err are valid while done is high.
- R3: Opcode 0 (pop) returns the run queue head in rsp_pid with rsp_err = 0 and removes it. Pids leave in the order they were queued.
- R4: A pop while the run queue holds only the idle slot returns pid 0 with rsp_err = 0 and changes neither list.
- R5: Opcode 1 (requeue) with a nonzero cmd_pid puts that pid after all queued non-idle pids and ahead of idle. rsp_pid echoes the pid and rsp_err = 0.
- R6: Opcode 2 (create) takes the spare pool head, returns it in rsp_pid with rsp_err = 0, and queues it on the run queue as in R5.
- R7: A create while the spare pool is empty returns rsp_err = 1 and rsp_pid = 0 and changes neither list.
- R8: Opcode 3 (retire) with a nonzero cmd_pid puts that pid at the spare pool tail. rsp_pid echoes the pid and rsp_err = 0. The spare pool hands out slots first-in first-out.
- R9: A requeue or retire naming pid 0 returns rsp_err = 1 and rsp_pid = 0 and changes neither list.
- R10: cmd_valid is ignored while busy is high. Nothing changes in either list, and no extra command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 pop, 1 requeue, 2 create, 3 retire |
| cmd_pid | input | PQ_PID_W | Target pid for requeue and retire |
| busy | output | 1 | Preset or command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_pid | output | PQ_PID_W | Result pid |
| rsp_err | output | 1 | Command refused |
| ready_head | output | PQ_PID_W | Run queue head (0 means only idle) |
| free_head | output | PQ_PID_W | Spare pool head (0 means empty) |

## Verification
The assertions and the list semantics rely on the scheduler naming, in requeue and retire, only pids that it holds itself. Such a pid came from a pop and sits in neither list. A pid that is already linked would corrupt the threading. The stimulus keeps a record of the pids it has popped and takes requeue and retire targets only from that record. Its deliberate misuses are limited to pid 0, to commands raised during busy, and to pops and creates on empty lists, all of which the block must refuse or absorb.

// File: rtl/pq_pkg.sv
package pq_pkg;
    parameter int unsigned PQ_PID_W = 3;
    localparam int unsigned NPROC = 1 << PQ_PID_W;

    typedef logic [PQ_PID_W-1:0] pid_t;
    localparam pid_t PID_MAX = pid_t'(NPROC - 1);

    typedef enum logic [1:0] {
        OP_POP    = 2'd0,
        OP_APPEND = 2'd1,
        OP_CREATE = 2'd2,
        OP_DELETE = 2'd3
    } pq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_A,
        ST_B,
        ST_C,
        ST_DONE
    } pq_state_e;

    typedef struct packed {
        logic we;
        pid_t addr;
        pid_t wdata;
    } link_req_t;

    // Preset value: slots 1..max chain upward, the last one and slot 0 end at 0
    function automatic pid_t init_link(pid_t idx);
        if (idx == PID_MAX || idx == '0) return '0;
        return idx + pid_t'(1);
    endfunction
endpackage

// File: rtl/pq_link_ram.sv
module pq_link_ram
    import pq_pkg::*;
(
    input  logic      clk,
    input  link_req_t req,
    output pid_t      rdata
);
    pid_t mem [NPROC];

    always_ff @(posedge clk) begin
        if (req.we) mem[req.addr] <= req.wdata;
        rdata <= mem[req.addr];
    end
endmodule

// File: rtl/pq_init_sweep.sv
module pq_init_sweep
    import pq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    output logic      active,
    output link_req_t req
);
    pid_t idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            idx <= idx + pid_t'(1);
            if (idx == PID_MAX) active <= 1'b0;
        end
    end

    always_comb begin
        req.we    = active;
        req.addr  = idx;
        req.wdata = init_link(idx);
    end
endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl
    import pq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      init_busy,
    input  logic      cmd_valid,
    input  pq_op_e    cmd_op,
    input  pid_t      cmd_pid,
    input  pid_t      ram_q,
    output link_req_t req,
    output logic      busy,
    output logic      done,
    output pid_t      rsp_pid,
    output logic      rsp_err,
    output pid_t      ready_head,
    output pid_t      free_head
);
    pq_state_e state;
    pq_op_e    op_r;
    pid_t      pid_r;
    logic      err_r;
    pid_t      rdy_head, rdy_last, fr_head, fr_tail;

    logic accept, act, pop_step, take_step, app_step, del_step;

    assign accept    = (state == ST_IDLE) && !init_busy && cmd_valid;
    assign act       = (pid_r != '0);
    assign pop_step  = act && state == ST_B && op_r == OP_POP;
    assign take_step = act && state == ST_B && op_r == OP_CREATE;
    assign app_step  = act && ((state == ST_B && op_r == OP_APPEND) ||
                               (state == ST_C && op_r == OP_CREATE));
    assign del_step  = act && state == ST_B && op_r == OP_DELETE;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) state <= ST_A;
                ST_A:    state <= ST_B;
                ST_B:    state <= ST_C;
                ST_C:    state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_r     <= OP_POP;
            pid_r    <= '0;
            err_r    <= 1'b0;
            rdy_head <= '0;
            rdy_last <= '0;
            fr_head  <= pid_t'(1);
            fr_tail  <= PID_MAX;
        end else begin
            if (accept) begin
                op_r <= cmd_op;
                unique case (cmd_op)
                    OP_POP: begin
                        pid_r <= rdy_head;
                        err_r <= 1'b0;
                    end
                    OP_CREATE: begin
                        pid_r <= fr_head;
                        err_r <= (fr_head == '0);
                    end
                    default: begin
                        pid_r <= cmd_pid;
                        err_r <= (cmd_pid == '0);
                    end
                endcase
            end
            if (pop_step) begin
                rdy_head <= ram_q;
                if (ram_q == '0) rdy_last <= '0;
            end
            if (take_step) begin
                fr_head <= ram_q;
                if (ram_q == '0) fr_tail <= '0;
            end
            if (app_step) begin
                if (rdy_last == '0) rdy_head <= pid_r;
                rdy_last <= pid_r;
            end
            if (del_step) begin
                if (fr_head == '0) fr_head <= pid_r;
                fr_tail <= pid_r;
            end
        end
    end

    // Link RAM port: one access per cycle
    always_comb begin
        req = '0;
        if (state == ST_A && act) begin
            req.addr  = pid_r;
            req.we    = (op_r == OP_APPEND) || (op_r == OP_DELETE);
            req.wdata = '0;
        end
        if (take_step) begin
            req.we    = 1'b1;
            req.addr  = pid_r;
            req.wdata = '0;
        end
        if (app_step && rdy_last != '0) begin
            req.we    = 1'b1;
            req.addr  = rdy_last;
            req.wdata = pid_r;
        end
        if (del_step && fr_head != '0) begin
            req.we    = 1'b1;
            req.addr  = fr_tail;
            req.wdata = pid_r;
        end
    end

    assign busy       = init_busy || (state != ST_IDLE);
    assign done       = (state == ST_DONE);
    assign rsp_pid    = pid_r;
    assign rsp_err    = err_r;
    assign ready_head = rdy_head;
    assign free_head  = fr_head;
endmodule

// File: rtl/pq_manager.sv
module pq_manager
    import pq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [PQ_PID_W-1:0] cmd_pid,
    output logic                busy,
    output logic                done,
    output logic [PQ_PID_W-1:0] rsp_pid,
    output logic                rsp_err,
    output logic [PQ_PID_W-1:0] ready_head,
    output logic [PQ_PID_W-1:0] free_head
);
    logic      init_active;
    link_req_t init_req, ctrl_req, ram_req;
    pid_t      ram_q;

    pq_init_sweep u_init (
        .clk    (clk),
        .rst    (rst),
        .active (init_active),
        .req    (init_req)
    );

    pq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .init_busy  (init_active),
        .cmd_valid  (cmd_valid),
        .cmd_op     (pq_op_e'(cmd_op)),
        .cmd_pid    (cmd_pid),
        .ram_q      (ram_q),
        .req        (ctrl_req),
        .busy       (busy),
        .done       (done),
        .rsp_pid    (rsp_pid),
        .rsp_err    (rsp_err),
        .ready_head (ready_head),
        .free_head  (free_head)
    );

    assign ram_req = init_active ? init_req : ctrl_req;

    pq_link_ram u_ram (
        .clk   (clk),
        .req   (ram_req),
        .rdata (ram_q)
    );
endmodule

// File: rtl/pq_manager_chk.sv
module pq_manager_chk
    import pq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       busy,
    input logic       done,
    input logic       rsp_err,
    input pid_t       rsp_pid,
    input pid_t       ready_head,
    input pid_t       free_head
);
    // R1: the preset keeps the block busy right after reset
    p_preset_busy_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy);

    // R2: done only inside a busy window
    p_done_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R2: done lasts one cycle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: a taken command raises busy next cycle without done
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid) |=> (busy && !done));

    // R4: an empty pop leaves only idle runnable
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !rsp_err && rsp_pid == '0) |-> ready_head == '0);

    // R7: a refused command does not move the heads
    p_refused_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_err) |-> ($stable(ready_head) && $stable(free_head)));

    // R10: with no command in flight the heads hold
    p_quiet_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_valid) |=> ($stable(ready_head) && $stable(free_head)));
endmodule

bind pq_manager pq_manager_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .done       (done),
    .rsp_err    (rsp_err),
    .rsp_pid    (rsp_pid),
    .ready_head (ready_head),
    .free_head  (free_head)
);

// File: tb/sim_pq_manager.sv
module sim_pq_manager;
    import pq_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cmd_valid = 1'b0;
    logic [1:0]          cmd_op = 2'd0;
    logic [PQ_PID_W-1:0] cmd_pid = '0;
    logic                busy, done, rsp_err;
    logic [PQ_PID_W-1:0] rsp_pid, ready_head, free_head;

    always #5 clk = ~clk;

    pq_manager u0 (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_pid    (cmd_pid),
        .busy       (busy),
        .done       (done),
        .rsp_pid    (rsp_pid),
        .rsp_err    (rsp_err),
        .ready_head (ready_head),
        .free_head  (free_head)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    summary_done = 0;

    // Behavioural reference
    int    init_left = 0;
    int    op_left = 0;
    int    rq[$];
    int    fq[$];
    int    e_pid = 0;
    bit    e_err = 0;
    string e_tag = "R1";
    bit    g_flag = 0;

    always @(posedge clk) begin
        if (rst) begin
            init_left = NPROC;
            op_left = 0;
            rq.delete();
            fq.delete();
            for (int i = 1; i < NPROC; i++) fq.push_back(i);
            e_tag = "R1";
        end else if (init_left > 0) begin
            init_left--;
        end else if (op_left > 0) begin
            op_left--;
        end else if (cmd_valid) begin
            op_left = 4;
            e_err = 0;
            case (cmd_op)
                2'd0: begin
                    if (rq.size() == 0) begin e_pid = 0; e_tag = "R4"; end
                    else begin e_pid = rq.pop_front(); e_tag = "R3"; end
                end
                2'd1: begin
                    e_pid = int'(cmd_pid);
                    if (e_pid == 0) begin e_err = 1; e_tag = "R9"; end
                    else begin rq.push_back(e_pid); e_tag = "R5"; end
                end
                2'd2: begin
                    if (fq.size() == 0) begin e_pid = 0; e_err = 1; e_tag = "R7"; end
                    else begin e_pid = fq.pop_front(); rq.push_back(e_pid); e_tag = "R6"; end
                end
                default: begin
                    e_pid = int'(cmd_pid);
                    if (e_pid == 0) begin e_err = 1; e_tag = "R9"; end
                    else begin fq.push_back(e_pid); e_tag = "R8"; end
                end
            endcase
            if (g_flag) e_tag = "R10";
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit    mb = (init_left > 0) || (op_left > 0);
            automatic string bt = (init_left > 0) ? "R1" : "R2";
            check(bt, "busy", int'(busy), int'(mb));
            check("R2", "done", int'(done), int'(op_left == 1));
            if (op_left == 1) begin
                check(e_tag, "rsp_pid", int'(rsp_pid), e_pid);
                check(e_tag, "rsp_err", int'(rsp_err), int'(e_err));
            end
            if (!mb) begin
                check(e_tag, "ready_head", int'(ready_head), (rq.size() > 0) ? rq[0] : 0);
                check(e_tag, "free_head", int'(free_head), (fq.size() > 0) ? fq[0] : 0);
            end
        end
    end

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        finish_run();
    end

    int held[$];

    task automatic issue(int op, int pid, bit glitch);
        @(negedge clk);
        while (busy) @(negedge clk);
        if (op == 0 && rq.size() > 0) held.push_back(rq[0]);
        if ((op == 1 || op == 3) && pid != 0) begin
            for (int i = 0; i < held.size(); i++)
                if (held[i] == pid) begin held.delete(i); break; end
        end
        g_flag    = glitch;
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_pid   = PQ_PID_W'(pid);
        @(negedge clk);
        if (glitch) begin
            cmd_op  = 2'd2;
            cmd_pid = PQ_PID_W'(NPROC - 1);
            repeat (3) @(negedge clk);
        end
        cmd_valid = 1'b0;
        g_flag    = 0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 preset window observed by the comparator
        issue(0, 0, 0);                 // R4 pop with only idle
        issue(1, 0, 0);                 // R9 requeue pid 0
        issue(3, 0, 0);                 // R9 retire pid 0
        issue(2, 0, 0);                 // R6 creates
        issue(2, 0, 0);
        issue(2, 0, 0);
        issue(0, 0, 0);                 // R3 pops in order
        issue(0, 0, 0);
        issue(1, 1, 0);                 // R5 requeue behind 3
        issue(3, 2, 0);                 // R8 retire to pool tail
        issue(0, 0, 1);                 // R10 command raised during busy
        for (int i = 0; i < NPROC; i++) issue(2, 0, 0);   // drain pool, then R7
        for (int i = 0; i < NPROC + 1; i++) issue(0, 0, 0);
        for (int k = 0; k < 400; k++) begin
            automatic int r = int'($urandom_range(0, 5));
            if ((r == 1 || r == 3 || r == 5) && held.size() > 0) begin
                automatic int j = int'($urandom_range(0, held.size() - 1));
                issue((r == 3) ? 3 : 1, held[j], (k % 37) == 0);
            end else if (r == 5) begin
                issue(1 + 2 * int'($urandom_range(0, 1)), 0, 0);
            end else if (r == 2 || r == 4) begin
                issue(2, 0, 0);
            end else begin
                issue(0, 0, (k % 41) == 0);
            end
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule